// File: doc/BRIEF.md
# Misaligned Transfer Bus Sequencer

This block sits between a CPU load/store unit and a 32-bit external data bus. It takes one data access and issues it as one or more bus cycles. The access is a read or write of a byte, word or longword at any byte address. An operand that is not naturally aligned, or that is wider than the memory port it targets, is never faulted. It is broken into as many narrower cycles as the address alignment and the port width require.

Each bus cycle presents a 24-bit byte address, a 2-bit size code, active-low byte strobes and, for writes, the operand bytes placed on the byte lanes that the port and address select. The cycle is held unchanged until the target acknowledges it. For reads, the returned lanes are gathered into one operand. The block then pulses `done`, and the operand is presented right-justified.

The port width is supplied with each request as 8, 16 or 32 bits. All operands are captured when the request is accepted, so the CPU side may change its request inputs while the block is busy.

Top module: `xfer_splitter`

## Requirements
- R1: After reset, `busy`, `done` and `bus_cyc` are low, and `bus_bs_n` is 4'b1111.
- R2: Size codes, used on both `req_size` and `bus_tsize`, are 2'b00 longword (4 bytes), 2'b01 byte and 2'b10 word (2 bytes); 2'b11 on `req_size` is taken as a longword. Port codes on `req_port` are 2'b00 for 32 bits, 2'b01 for 8 bits and 2'b10 for 16 bits.
- R3: Each cycle uses the largest of 4, 2 or 1 bytes that is naturally aligned at the current address, does not exceed the bytes still to move, and is not wider than the port. The next cycle starts at the address just past it, so the access covers exactly the operand's bytes in rising address order.
- R4: The number of low strobes equals the size in `bus_tsize`. Lanes are big-endian: on a 32-bit port, address offset j (0..3) within the word uses `bus_wdata[31-8j -: 8]` and strobe bit 3-j. A 16-bit port uses only lanes 0 and 1 (bits 31:16, strobes 3 and 2), selected by address bit 0. An 8-bit port uses only lane 0 (bits 31:24, strobe 3).
- R5: On a write, each strobed lane carries the operand byte for that lane's address, with the most significant operand byte at the lowest address. Unstrobed lanes are driven to zero.
- R6: While `bus_cyc` is high and `bus_ack` is low, address, size, strobes and write data hold their values into the next cycle.
- R7: On a read, `rdata` holds the operand when `done` is high, right-justified, with the byte from the lowest address most significant. Unstrobed lanes of `bus_rdata` have no effect.
- R8: `done` is a one-cycle pulse in the cycle after the last acknowledge. No bus cycle is driven while `done` is high. `busy` is high from acceptance through the last acknowledged cycle.
- R9: `req` is ignored while `busy` or `done` is high. Changes to the request inputs after acceptance do not affect the access in progress.
- R10: A longword at an address whose two low bits are 3, on a 32-bit port, takes three cycles: a byte with strobes 4'b1110, then a word, then a byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Operand size code |
| req_port | input | 2 | Port width code |
| req_addr | input | 24 | Byte address of the operand |
| req_wdata | input | 32 | Write operand, right-justified |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read operand, right-justified |
| bus_cyc | output | 1 | Bus cycle active |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | 24 | Bus cycle byte address |
| bus_tsize | output | 2 | Bus cycle size code |
| bus_bs_n | output | 4 | Active-low byte-lane strobes |
| bus_wdata | output | 32 | Write data on byte lanes |
| bus_rdata | input | 32 | Read data from byte lanes |
| bus_ack | input | 1 | Cycle acknowledge |

## Verification
The final acknowledge of an access falls in the same cycle as the capture of the last read bytes, the right-justification of the result and the move to `done`. The address advance and the choice of the next cycle's size also coincide with each acknowledge. The bench drives a zero-wait acknowledge, raised in the first cycle that a bus cycle appears, on one third of all access forms. It also drives one- and two-wait acknowledges to provoke the hold case. Each access is judged against a byte-array memory model, by comparing the result or the written bytes, and by checking the cycle count and the lane placement of every cycle. The request stays high and its inputs are scrambled during the access, so any re-acceptance or late capture shows up in the same comparisons.

// File: rtl/xfer_splitter.sv
module xfer_splitter #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [1:0]    req_port,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          busy,
  output logic          done,
  output logic [31:0]   rdata,
  output logic          bus_cyc,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_tsize,
  output logic [3:0]    bus_bs_n,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_ack
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  st_t st;

  logic [AW-1:0] base;
  logic [2:0]    cnt, n_q, pw_q;
  logic          we_q;
  logic [31:0]   opl, asm_q, rdata_q;

  logic [2:0] n_in, pw_in, rem, sz;
  logic [1:0] lb;
  logic [3:0] lanes;
  logic [31:0] dmask, piece, asm_nxt;
  logic [AW-1:0] cur;

  assign n_in  = (req_size == 2'b01) ? 3'd1 : (req_size == 2'b10) ? 3'd2 : 3'd4;
  assign pw_in = (req_port == 2'b01) ? 3'd1 : (req_port == 2'b10) ? 3'd2 : 3'd4;

  assign cur = base + AW'(cnt);
  assign rem = n_q - cnt;

  always_comb begin
    if (pw_q == 3'd4 && cur[1:0] == 2'b00 && rem >= 3'd4) sz = 3'd4;
    else if (pw_q >= 3'd2 && !cur[0] && rem >= 3'd2)     sz = 3'd2;
    else                                                  sz = 3'd1;
    case (pw_q)
      3'd4:    lb = cur[1:0];
      3'd2:    lb = {1'b0, cur[0]};
      default: lb = 2'd0;
    endcase
  end

  assign lanes   = (4'hF << (3'd4 - sz)) >> lb;
  assign dmask   = {{8{lanes[3]}}, {8{lanes[2]}}, {8{lanes[1]}}, {8{lanes[0]}}};
  assign piece   = ((bus_rdata & dmask) << {lb, 3'b000}) >> {cnt, 3'b000};
  assign asm_nxt = asm_q | piece;

  assign busy      = (st == S_RUN);
  assign done      = (st == S_FIN);
  assign bus_cyc   = (st == S_RUN);
  assign bus_we    = bus_cyc & we_q;
  assign bus_addr  = cur;
  assign bus_tsize = (sz == 3'd4) ? 2'b00 : (sz == 3'd2) ? 2'b10 : 2'b01;
  assign bus_bs_n  = bus_cyc ? ~lanes : 4'hF;
  assign bus_wdata = bus_we ? (((opl << {cnt, 3'b000}) >> {lb, 3'b000}) & dmask) : 32'h0;
  assign rdata     = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      base <= '0;
      cnt <= '0;
      n_q <= '0;
      pw_q <= 3'd4;
      we_q <= 1'b0;
      opl <= '0;
      asm_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          base  <= req_addr;
          n_q   <= n_in;
          pw_q  <= pw_in;
          we_q  <= req_write;
          opl   <= req_wdata << {3'd4 - n_in, 3'b000};
          asm_q <= '0;
          cnt   <= '0;
          st    <= S_RUN;
        end
        S_RUN: if (bus_ack) begin
          asm_q <= asm_nxt;
          cnt   <= cnt + sz;
          if (sz == rem) begin
            rdata_q <= asm_nxt >> {3'd4 - n_q, 3'b000};
            st      <= S_FIN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4
  tsize_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> $countones(~bus_bs_n) ==
      ((bus_tsize == 2'b00) ? 4 : (bus_tsize == 2'b10) ? 2 : 1));

  // R3
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> (bus_tsize != 2'b00 || bus_addr[1:0] == 2'b00) &&
                (bus_tsize != 2'b10 || !bus_addr[0]));

  // R4
  port_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> (pw_q != 3'd1 || bus_bs_n[2:0] == 3'b111) &&
                (pw_q != 3'd2 || bus_bs_n[1:0] == 2'b11));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && !bus_ack |=> bus_cyc && $stable(bus_addr) && $stable(bus_tsize) &&
                            $stable(bus_bs_n) && $stable(bus_wdata));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !bus_cyc);

  // R1
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cyc |-> bus_bs_n == 4'hF);

endmodule

// File: tb/sim_xfer_splitter.sv
module sim_xfer_splitter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_write = 1'b0;
  logic [1:0] req_size = 2'b00, req_port = 2'b00;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic busy, done, bus_cyc, bus_we;
  logic [31:0] rdata, bus_wdata;
  logic [23:0] bus_addr;
  logic [1:0] bus_tsize;
  logic [3:0] bus_bs_n;
  logic [31:0] bus_rdata = '0;
  logic bus_ack = 1'b0;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 1'b0;
  logic [7:0] mem [32];
  logic [7:0] snap [32];

  always #5 clk = ~clk;

  xfer_splitter u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
    .req_size(req_size), .req_port(req_port), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
    .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_tsize(bus_tsize), .bus_bs_n(bus_bs_n), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_cycles(input int n, input int pwb, input int al);
    int c = 0, o = 0, s, a;
    while (o < n) begin
      a = (al + o) % 4;
      if (pwb == 4 && a == 0 && n - o >= 4) s = 4;
      else if (pwb >= 2 && a % 2 == 0 && n - o >= 2) s = 2;
      else s = 1;
      o += s;
      c++;
    end
    return c;
  endfunction

  task automatic run(input bit wr, input logic [1:0] sz, input logic [1:0] pc,
                     input int al, input int dly);
    int n, pwb, ncyc, wcnt, tries, tsz, bad;
    int seq [8];
    logic [23:0] addr, lbase, ba;
    logic [31:0] op, expv, wd;
    logic [3:0] s, allowed, first_bs;
    bit got;
    n = (sz == 2'b01) ? 1 : (sz == 2'b10) ? 2 : 4;
    pwb = (pc == 2'b01) ? 1 : (pc == 2'b10) ? 2 : 4;
    addr = 24'hA55A10 + 24'(al);
    for (int i = 0; i < 32; i++) begin
      mem[i] = 8'(i * 37 + al * 11 + dly + 5);
      snap[i] = mem[i];
    end
    op = $urandom;
    if (n < 4) op = op & ((32'h1 << (8 * n)) - 1);
    req = 1'b1; req_write = wr; req_size = sz; req_port = pc;
    req_addr = addr; req_wdata = op;
    ncyc = 0; wcnt = 0; tries = 0; got = 1'b0; bad = 0; first_bs = 4'hF;
    while (!got && tries < 300) begin
      @(negedge clk);
      tries++;
      bus_ack = 1'b0;
      if (tries == 2) begin
        req_addr = ~addr; req_wdata = ~op; req_size = ~sz; req_port = ~pc; req_write = ~wr;
      end
      if (done) begin
        got = 1'b1;
        req = 1'b0;
        if (!wr) begin
          expv = '0;
          for (int k = 0; k < n; k++) expv = (expv << 8) | 32'(mem[5'(addr + 24'(k))]);
          chk(rdata == expv, "R7 read result", rdata, expv);
        end
      end else if (bus_cyc) begin
        if (!busy) bad++;
        if (wcnt == dly) begin
          wcnt = 0;
          bus_ack = 1'b1;
          s = ~bus_bs_n;
          allowed = (pwb == 4) ? 4'hF : (pwb == 2) ? 4'hC : 4'h8;
          if ((s & ~allowed) != 0) bad++;
          lbase = (pwb == 4) ? {bus_addr[23:2], 2'b00} : (pwb == 2) ? {bus_addr[23:1], 1'b0} : bus_addr;
          tsz = (bus_tsize == 2'b00) ? 4 : (bus_tsize == 2'b10) ? 2 : 1;
          if ($countones(s) != tsz) bad++;
          if (ncyc < 8) seq[ncyc] = tsz;
          if (ncyc == 0) first_bs = bus_bs_n;
          bus_rdata = $urandom;
          wd = bus_wdata;
          for (int j = 0; j < 4; j++) begin
            ba = lbase + 24'(j);
            if (s[3 - j]) begin
              if (ba < addr || ba >= addr + 24'(n)) bad++;
              if (wr) begin
                if (wd[31 - 8 * j -: 8] != op[8 * (n - 1 - int'(ba - addr)) +: 8]) bad++;
                mem[ba[4:0]] = wd[31 - 8 * j -: 8];
              end else begin
                bus_rdata[31 - 8 * j -: 8] = mem[ba[4:0]];
              end
            end else if (wr && wd[31 - 8 * j -: 8] != 8'h00) bad++;
          end
          ncyc++;
        end else wcnt++;
      end
    end
    chk(got, "R8 done reached", 32'(got), 32'd1);
    chk(bad == 0, "R4 R5 lanes/strobes per cycle", 32'(bad), 32'd0);
    chk(ncyc == exp_cycles(n, pwb, al), "R3 R9 cycle count", 32'(ncyc), 32'(exp_cycles(n, pwb, al)));
    if (wr) begin
      bad = 0;
      for (int i = 0; i < 32; i++) begin
        if (5'(i) - addr[4:0] < 5'(n)) begin
          if (mem[i] != op[8 * (n - 1 - int'(5'(i) - addr[4:0])) +: 8]) bad++;
        end else if (mem[i] != snap[i]) bad++;
      end
      chk(bad == 0, "R5 written memory", 32'(bad), 32'd0);
    end
    if (pc == 2'b00 && sz == 2'b00 && al == 3) begin
      chk(first_bs == 4'b1110, "R10 first strobes", 32'(first_bs), 32'hE);
      chk(seq[0] == 1 && seq[1] == 2 && seq[2] == 1, "R10 size order",
          32'(seq[0] * 100 + seq[1] * 10 + seq[2]), 32'd121);
    end
    @(negedge clk);
    bus_ack = 1'b0;
    chk(!done && !bus_cyc && !busy, "R8 R9 single done, no restart",
        {29'b0, done, bus_cyc, busy}, 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int idx = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_cyc && bus_bs_n == 4'hF, "R1 reset state",
        {25'b0, busy, done, bus_cyc, bus_bs_n}, 32'h0000000F);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !bus_cyc, "R1 idle after reset", {30'b0, busy, bus_cyc}, 32'd0);
    for (int w = 0; w < 2; w++)
      for (int p = 0; p < 3; p++)
        for (int z = 0; z < 3; z++)
          for (int a = 0; a < 4; a++) begin
            run(w[0], 2'(z), 2'(p), a, idx % 3);   // R2 encodings swept
            idx++;
          end
    run(1'b0, 2'b11, 2'b00, 1, 0);   // R2 code 11 taken as longword
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule